// File: doc/BRIEF.md
# Partial-Decode Memory and Port Select Unit

This unit sits between a bus master with a 16-bit address and the devices hanging off a small system bus. It turns the read and write strobes and two space qualifiers, one for memory and one for I/O, into active-high enables for a RAM array, a memory-mapped peripheral window and a single I/O-space register. The memory-mapped window covers the top quarter of the address range. The unit tests only the two most significant address lines to find it. The I/O port is found by testing only address bit 0, so half of the I/O address space aliases onto that one port. For this reason only those address lines are wired into the block.

A one-bit mapping register chooses what the top window reaches. When the register is set, the peripheral answers there and RAM stays silent. When it is clear, the RAM cells at the same addresses are visible. Software changes this register by writing to the I/O port, and the new value comes from data bus bit 0. The unit also watches for a master that asserts both qualifiers at once. In that case it drives no enable and raises a sticky conflict indicator, which only reset clears.

Top module: `bus_select_decoder`

## Requirements
- R1: A memory access (memory qualifier, read or write strobe) with both upper address lines high asserts `dev_en` and keeps `ram_en` low while the mapping register is 1.
- R2: A memory access asserts `ram_en` whenever the upper address lines are not both high. It also asserts `ram_en` inside the upper window when the mapping register is 0, and `dev_en` then stays low.
- R3: `ram_en` and `dev_en` need the memory qualifier, and `port_en` needs the I/O qualifier. With the same address on the bus, a memory access never enables the port and an I/O access never enables RAM or the peripheral.
- R4: `port_en` rises on an I/O read or write when address bit 0 equals `PORT_LSB` (default 0, so every even I/O address). No other address bit is examined, and all aliases select the port identically.
- R5: No enable is asserted while neither the read strobe nor the write strobe is active.
- R6: While both qualifiers are active, all three enables are low.
- R7: The mapping register is 1 during and after reset. An I/O write that selects the port loads data bit 0 into it from the next clock edge on. I/O reads, I/O writes to non-matching addresses and memory writes leave it unchanged.
- R8: `conflict` is 0 after reset. It goes to 1 on the clock edge after a cycle with both qualifiers active, and it then stays 1 until reset.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| addr_top | input | WIN_BITS (2) | Most significant address lines, A15 and A14 |
| addr_lsb | input | 1 | Address line A0 |
| dbit0 | input | 1 | Data bus bit 0, value written to the mapping register |
| rd | input | 1 | Read strobe, active high |
| wr | input | 1 | Write strobe, active high |
| mreq | input | 1 | Memory-space qualifier, active high |
| iorq | input | 1 | I/O-space qualifier, active high |
| ram_en | output | 1 | RAM enable |
| dev_en | output | 1 | Memory-mapped peripheral window enable |
| port_en | output | 1 | I/O port enable |
| conflict | output | 1 | Sticky flag for both qualifiers seen together |

## Verification
Some properties are checked by the assertions on every cycle. RAM and the peripheral are never enabled together, and a memory enable never coincides with the port enable. A memory enable always has its qualifier. Nothing is enabled without a strobe or while both qualifiers are active. The port enable and the window enable agree with the address lines they examine. The conflict flag rises after a conflict and stays up. Other behaviours depend on history and on specific values, so only the bench scenarios can show them. These are the reset value of the mapping register, the one-edge delay before a port write changes what the window reaches, the fact that I/O reads, odd-address writes and memory writes leave the register alone, and the identical selection of aliased even I/O addresses.

// File: rtl/bus_dec_pkg.sv
package bus_dec_pkg;

    typedef struct packed {
        logic map_on;     // 1: upper window reaches the peripheral
        logic conflict;   // sticky: both qualifiers were seen together
    } dec_ctrl_t;

    typedef struct packed {
        logic acc;        // some strobe active
        logic clash;      // both qualifiers active
        logic mem_ok;     // clean memory-space access
        logic io_ok;      // clean I/O-space access
    } qual_t;

endpackage

// File: rtl/bus_qualify.sv
module bus_qualify
    import bus_dec_pkg::*;
(
    input  logic  rd,
    input  logic  wr,
    input  logic  mreq,
    input  logic  iorq,
    output qual_t q
);
    always_comb begin
        q.acc    = rd | wr;
        q.clash  = mreq & iorq;
        q.mem_ok = mreq & ~iorq & q.acc;
        q.io_ok  = iorq & ~mreq & q.acc;
    end
endmodule

// File: rtl/bus_mem_decode.sv
module bus_mem_decode #(
    parameter int WIN_BITS = 2
) (
    input  logic [WIN_BITS-1:0] addr_top,
    input  logic                mem_ok,
    input  logic                map_on,
    output logic                ram_sel,
    output logic                dev_sel
);
    localparam logic [WIN_BITS-1:0] WIN_PATTERN = {WIN_BITS{1'b1}};

    logic in_window;

    always_comb begin
        in_window = (addr_top == WIN_PATTERN);
        dev_sel   = mem_ok & in_window & map_on;
        ram_sel   = mem_ok & ~(in_window & map_on);
    end
endmodule

// File: rtl/bus_io_decode.sv
module bus_io_decode #(
    parameter bit PORT_LSB = 1'b0
) (
    input  logic addr_lsb,
    input  logic io_ok,
    input  logic wr,
    output logic port_sel,
    output logic port_wr
);
    logic hit;

    generate
        if (PORT_LSB) begin : g_odd
            assign hit = addr_lsb;
        end else begin : g_even
            assign hit = ~addr_lsb;
        end
    endgenerate

    always_comb begin
        port_sel = io_ok & hit;
        port_wr  = port_sel & wr;
    end
endmodule

// File: rtl/bus_shadow_ctrl.sv
module bus_shadow_ctrl
    import bus_dec_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic load,
    input  logic load_val,
    input  logic clash,
    output logic map_on,
    output logic conflict
);
    dec_ctrl_t ctrl_d, ctrl_q;

    always_comb begin
        ctrl_d = ctrl_q;
        if (load) begin
            ctrl_d.map_on = load_val;
        end
        if (clash) begin
            ctrl_d.conflict = 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ctrl_q <= '{map_on: 1'b1, conflict: 1'b0};
        end else begin
            ctrl_q <= ctrl_d;
        end
    end

    assign map_on   = ctrl_q.map_on;
    assign conflict = ctrl_q.conflict;
endmodule

// File: rtl/bus_select_decoder.sv
module bus_select_decoder
    import bus_dec_pkg::*;
#(
    parameter int WIN_BITS = 2,
    parameter bit PORT_LSB = 1'b0
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic [WIN_BITS-1:0] addr_top,
    input  logic                addr_lsb,
    input  logic                dbit0,
    input  logic                rd,
    input  logic                wr,
    input  logic                mreq,
    input  logic                iorq,
    output logic                ram_en,
    output logic                dev_en,
    output logic                port_en,
    output logic                conflict
);
    qual_t qual;
    logic  map_on;
    logic  port_wr;

    bus_qualify u_qual (
        .rd   (rd),
        .wr   (wr),
        .mreq (mreq),
        .iorq (iorq),
        .q    (qual)
    );

    bus_mem_decode #(.WIN_BITS(WIN_BITS)) u_mem (
        .addr_top (addr_top),
        .mem_ok   (qual.mem_ok),
        .map_on   (map_on),
        .ram_sel  (ram_en),
        .dev_sel  (dev_en)
    );

    bus_io_decode #(.PORT_LSB(PORT_LSB)) u_io (
        .addr_lsb (addr_lsb),
        .io_ok    (qual.io_ok),
        .wr       (wr),
        .port_sel (port_en),
        .port_wr  (port_wr)
    );

    bus_shadow_ctrl u_ctrl (
        .clk      (clk),
        .rst_n    (rst_n),
        .load     (port_wr),
        .load_val (dbit0),
        .clash    (qual.clash),
        .map_on   (map_on),
        .conflict (conflict)
    );
endmodule

// File: rtl/bus_select_decoder_chk.sv
module bus_select_decoder_chk #(
    parameter int WIN_BITS = 2,
    parameter bit PORT_LSB = 1'b0
) (
    input logic                clk,
    input logic                rst_n,
    input logic [WIN_BITS-1:0] addr_top,
    input logic                addr_lsb,
    input logic                dbit0,
    input logic                rd,
    input logic                wr,
    input logic                mreq,
    input logic                iorq,
    input logic                ram_en,
    input logic                dev_en,
    input logic                port_en,
    input logic                conflict
);
    AST_RAM_DEV_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
        !(ram_en && dev_en)); // R1
    AST_DEV_IN_WINDOW: assert property (@(posedge clk) disable iff (!rst_n)
        dev_en |-> (&addr_top)); // R1
    AST_MEM_NEEDS_MREQ: assert property (@(posedge clk) disable iff (!rst_n)
        (ram_en || dev_en) |-> (mreq && !port_en)); // R3
    AST_PORT_NEEDS_IORQ: assert property (@(posedge clk) disable iff (!rst_n)
        port_en |-> iorq); // R3
    AST_PORT_LSB_MATCH: assert property (@(posedge clk) disable iff (!rst_n)
        port_en |-> (addr_lsb == PORT_LSB)); // R4
    AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        !(rd || wr) |-> $countones({ram_en, dev_en, port_en}) == 0); // R5
    AST_CLASH_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        (mreq && iorq) |-> !(ram_en || dev_en || port_en)); // R6
    AST_FLAG_RISES: assert property (@(posedge clk) disable iff (!rst_n)
        (mreq && iorq) |=> conflict); // R8
    AST_FLAG_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        conflict |=> conflict); // R8

    logic unused_ok;
    assign unused_ok = dbit0;
endmodule

bind bus_select_decoder bus_select_decoder_chk #(
    .WIN_BITS(WIN_BITS),
    .PORT_LSB(PORT_LSB)
) u_chk (.*);

// File: tb/bus_select_decoder_bench.sv
module bus_select_decoder_bench;

    typedef struct {
        logic [3:0] exp;   // {ram_en, dev_en, port_en, conflict}
        string      req;
    } item_t;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [15:0] addr = 16'h0000;
    logic        dbit0 = 1'b0;
    logic        rd = 1'b0, wr = 1'b0, mreq = 1'b0, iorq = 1'b0;
    logic        ram_en, dev_en, port_en, conflict;

    int    total = 0;
    int    bad = 0;
    bit    done = 1'b0;
    item_t sb[$];

    bit m_map  = 1'b1;
    bit m_flag = 1'b0;

    always #10 clk = ~clk; // 50 MHz

    bus_select_decoder u_bus_select_decoder (
        .clk      (clk),
        .rst_n    (rst_n),
        .addr_top (addr[15:14]),
        .addr_lsb (addr[0]),
        .dbit0    (dbit0),
        .rd       (rd),
        .wr       (wr),
        .mreq     (mreq),
        .iorq     (iorq),
        .ram_en   (ram_en),
        .dev_en   (dev_en),
        .port_en  (port_en),
        .conflict (conflict)
    );

    function automatic logic [3:0] expect_of(logic [15:0] a, bit r, bit w, bit mq, bit io);
        bit acc, memok, win, dev, ram, prt;
        acc   = r | w;
        memok = mq & !io & acc;
        win   = a[15] & a[14];
        dev   = memok & win & m_map;
        ram   = memok & !(win & m_map);
        prt   = io & !mq & acc & (a[0] == 1'b0);
        return {ram, dev, prt, m_flag};
    endfunction

    task automatic put(logic [15:0] a, bit r, bit w, bit mq, bit io, bit d);
        addr = a; rd = r; wr = w; mreq = mq; iorq = io; dbit0 = d;
    endtask

    // Driver: drives one bus cycle, pushes the expected enables, then updates the model.
    task automatic cyc(logic [15:0] a, bit r, bit w, bit mq, bit io, bit d, string req);
        item_t it;
        @(posedge clk);
        #2;
        put(a, r, w, mq, io, d);
        it.exp = expect_of(a, r, w, mq, io);
        it.req = req;
        sb.push_back(it);
        if (mq && io) m_flag = 1'b1;
        if (io && !mq && w && a[0] == 1'b0) m_map = d;
    endtask

    task automatic do_reset();
        item_t it;
        @(posedge clk);
        #2;
        rst_n = 1'b0;
        m_map = 1'b1;
        m_flag = 1'b0;
        put(16'hC000, 1'b1, 1'b0, 1'b1, 1'b0, 1'b0);
        it.exp = expect_of(16'hC000, 1'b1, 1'b0, 1'b1, 1'b0);
        it.req = "R7 R8 reset state";
        sb.push_back(it);
        @(posedge clk);
        #2;
        put(16'h0000, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0);
        rst_n = 1'b1;
    endtask

    // Monitor: compares outputs mid-cycle against the scoreboard.
    initial begin
        forever begin
            @(negedge clk);
            while (sb.size() > 0) begin
                item_t it;
                logic [3:0] act;
                it  = sb.pop_front();
                act = {ram_en, dev_en, port_en, conflict};
                total++;
                if (act !== it.exp) begin
                    bad++;
                    $display("FAIL %s: actual {ram,dev,port,flag}=%b expected=%b", it.req, act, it.exp);
                end
            end
        end
    end

    initial begin
        repeat (5000) @(posedge clk);
        if (!done) begin
            total++;
            bad++;
            $display("FAIL watchdog: actual=hung expected=finished");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        do_reset();
        // R2: RAM below the window
        cyc(16'h0000, 1, 0, 1, 0, 0, "R2 ram read low");
        cyc(16'h8000, 0, 1, 1, 0, 0, "R2 ram write 8000");
        cyc(16'hBFFF, 1, 0, 1, 0, 0, "R2 ram edge BFFF");
        // R1: window reaches peripheral
        cyc(16'hC000, 1, 0, 1, 0, 0, "R1 dev read C000");
        cyc(16'hFFFF, 0, 1, 1, 0, 0, "R1 dev write FFFF");
        cyc(16'hD3A5, 1, 0, 1, 0, 0, "R1 dev read D3A5");
        // R3: same address in the two spaces
        cyc(16'h1234, 1, 0, 1, 0, 0, "R3 mem read 1234 no port");
        cyc(16'h1234, 1, 0, 0, 1, 0, "R3 io read 1234 no ram");
        cyc(16'hC002, 1, 0, 0, 1, 0, "R3 io read C002 no dev");
        // R4: aliasing of even addresses, odd misses
        cyc(16'h0000, 1, 0, 0, 1, 0, "R4 alias 0000");
        cyc(16'hFFFE, 1, 0, 0, 1, 0, "R4 alias FFFE");
        cyc(16'h7F02, 1, 0, 0, 1, 0, "R4 alias 7F02");
        cyc(16'h0035, 1, 0, 0, 1, 0, "R4 odd miss 0035");
        cyc(16'hFFFF, 0, 1, 0, 1, 1, "R4 odd write miss FFFF");
        // R5: no strobe
        cyc(16'hC000, 0, 0, 1, 0, 0, "R5 mem no strobe");
        cyc(16'h0000, 0, 0, 0, 1, 0, "R5 io no strobe");
        // R7: mapping register
        cyc(16'h0010, 0, 1, 0, 1, 0, "R7 port write clears map");
        cyc(16'hC000, 1, 0, 1, 0, 0, "R7 R2 window now ram");
        cyc(16'h0021, 0, 1, 0, 1, 1, "R7 odd write ignored");
        cyc(16'hE000, 1, 0, 1, 0, 0, "R7 map still 0 after odd write");
        cyc(16'h0002, 1, 0, 0, 1, 1, "R7 io read ignored");
        cyc(16'hC000, 0, 1, 1, 0, 1, "R7 mem write ignored");
        cyc(16'hF000, 1, 0, 1, 0, 0, "R7 map still 0 after read/memwrite");
        cyc(16'hAAAA, 0, 1, 0, 1, 1, "R7 port write sets map");
        cyc(16'hC000, 1, 0, 1, 0, 0, "R7 R1 window dev again");
        // R6 / R8: both qualifiers
        cyc(16'hC000, 1, 0, 1, 1, 0, "R6 clash window");
        cyc(16'h0000, 0, 1, 1, 1, 0, "R6 clash port write");
        cyc(16'hC000, 1, 0, 1, 0, 0, "R8 flag set, map unchanged");
        cyc(16'h0000, 0, 0, 0, 0, 0, "R8 flag sticky idle");
        cyc(16'h4000, 1, 0, 1, 0, 0, "R8 flag sticky ram");
        // reset clears flag and restores map
        cyc(16'h0000, 0, 1, 0, 1, 0, "R7 clear map before reset");
        do_reset();
        cyc(16'hC000, 1, 0, 1, 0, 0, "R7 R8 after second reset");
        @(posedge clk);
        #2;
        put(16'h0000, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0);
        repeat (2) @(negedge clk);
        done = 1'b1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule